// File: doc/BRIEF.md
# Epoch-Cleared Block-RAM Table

This block is a single-clock lookup table that synthesis can place in on-chip block RAM. One write port and one registered read port are the only paths into the storage array. The array's contents are never reset. Each entry holds a generation tag next to its data. The whole table is cleared in one cycle by advancing a global epoch counter. A read whose stored tag differs from the current epoch returns zero data and reports a miss.

The epoch counter is finite, so a clear that would move it back to a value that old entries may still carry does something else. It starts a sequential scrub that uses the write port to stamp every address with a reserved tag that never matches. The same scrub runs after reset, because the array powers up with unknown tags. While the scrub runs, `busy_o` is high, writes and clears are not accepted, and every read misses. A requester that sees `busy_o` must hold its write until the flag drops.

Top module: `epoch_clear_table`

## Requirements
- R1: After reset is released, `busy_o` is high for exactly DEPTH cycles and `rd_valid_o` is low; once `busy_o` falls, every address reads as a miss until it is written.
- R2: `rd_valid_o` is high in the cycle after a cycle with `rd_en_i` high and low otherwise; `rd_hit_o` is never high without `rd_valid_o`.
- R3: A write accepted while `busy_o` is low is returned by a later read of the same address with `rd_hit_o` high and the written data, provided no clear has been accepted in between.
- R4: A read that misses drives `rd_data_o` to all zeros and `rd_hit_o` low.
- R5: A clear accepted while `busy_o` is low makes every entry written before it read as a miss from the next cycle on. If the epoch does not wrap, `busy_o` stays low.
- R6: A write issued in the same cycle as a non-wrapping clear is kept and hits on later reads.
- R7: A read and a write to the same address in the same cycle return the contents as they were before the write (read-first).
- R8: Usable epochs run from 0 to 2^TAG_W-2. The clear that would advance past 2^TAG_W-2 resets the epoch to 0, drops any write in the same cycle, and raises `busy_o` for exactly DEPTH cycles starting in the next cycle. All entries then read as misses.
- R9: A write issued while `busy_o` is high is ignored; the address still reads as a miss after `busy_o` falls.
- R10: A clear issued while `busy_o` is high has no effect and does not lengthen the busy period.
- R11: A read issued while `busy_o` is high returns a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the control registers |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | $clog2(DEPTH) | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | $clog2(DEPTH) | Read address, presented one cycle before the data |
| clr_i | input | 1 | Whole-table clear request |
| busy_o | output | 1 | Scrub in progress; writes and clears are not accepted |
| rd_valid_o | output | 1 | Read result present |
| rd_hit_o | output | 1 | Read entry belongs to the current epoch |
| rd_data_o | output | DATA_W | Read data, zero on a miss |

## Verification
The bench builds the table with DEPTH=8, DATA_W=8 and TAG_W=2. With these values only three epochs are usable, so every third accepted clear wraps and triggers a scrub. The bench therefore crosses the wrap boundary many times within a short random run. Each scrub lasts just eight cycles, which keeps cases such as writes, clears and reads landing during a scrub, or in its last cycle, frequent rather than rare.

// File: rtl/etab_pkg.sv
package etab_pkg;
  typedef enum logic [0:0] {
    CTL_RUN   = 1'b0,
    CTL_SCRUB = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/etab_ram.sv
// Inferrable storage: one write port, registered read, no reset on contents.
module etab_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 36,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/etab_ctrl.sv
// Epoch counter, scrub sequencer and write-port arbitration.
module etab_ctrl
  import etab_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned EW    = TAG_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic [TAG_W-1:0]  epoch_o,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_addr_o,
  output logic [EW-1:0]     ram_wdata_o
);
  localparam logic [TAG_W-1:0] TAG_DEAD   = '1;
  localparam logic [TAG_W-1:0] EPOCH_LAST = TAG_DEAD - TAG_W'(1);
  localparam logic [AW-1:0]    IDX_LAST   = AW'(DEPTH - 1);

  ctl_state_e       state_q, state_d;
  logic [AW-1:0]    idx_q, idx_d;
  logic [TAG_W-1:0] epoch_q, epoch_d;
  logic             clr_ok, wrap;

  assign clr_ok = clr_i && (state_q == CTL_RUN);
  assign wrap   = clr_ok && (epoch_q == EPOCH_LAST);

  always_comb begin
    epoch_d = epoch_q;
    if (clr_ok) epoch_d = wrap ? '0 : epoch_q + TAG_W'(1);
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      CTL_RUN: begin
        if (wrap) begin
          state_d = CTL_SCRUB;
          idx_d   = '0;
        end
      end
      CTL_SCRUB: begin
        idx_d = idx_q + AW'(1);
        if (idx_q == IDX_LAST) begin
          state_d = CTL_RUN;
          idx_d   = '0;
        end
      end
      default: state_d = CTL_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CTL_SCRUB;  // array powers up with unknown tags
      idx_q   <= '0;
      epoch_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      epoch_q <= epoch_d;
    end
  end

  // Write port: scrub owns it while active; a wrapping clear drops the write.
  always_comb begin
    if (state_q == CTL_SCRUB) begin
      ram_we_o    = 1'b1;
      ram_addr_o  = idx_q;
      ram_wdata_o = {TAG_DEAD, {DATA_W{1'b0}}};
    end else begin
      ram_we_o    = wr_en_i && !wrap;
      ram_addr_o  = wr_addr_i;
      ram_wdata_o = {epoch_d, wr_data_i};
    end
  end

  assign busy_o  = (state_q == CTL_SCRUB);
  assign epoch_o = epoch_q;
endmodule

// File: rtl/etab_rdstage.sv
// Read qualification: snapshot epoch and scrub state alongside the RAM read.
module etab_rdstage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned EW    = TAG_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [TAG_W-1:0]  epoch_i,
  input  logic              busy_i,
  input  logic [EW-1:0]     ram_rdata_i,
  output logic              rd_valid_o,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic             valid_q, dead_q;
  logic [TAG_W-1:0] epoch_snap_q;
  logic [TAG_W-1:0] tag;
  logic             hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q      <= 1'b0;
      dead_q       <= 1'b0;
      epoch_snap_q <= '0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) begin
        dead_q       <= busy_i;
        epoch_snap_q <= epoch_i;
      end
    end
  end

  assign tag        = ram_rdata_i[EW-1:DATA_W];
  assign hit        = valid_q && !dead_q && (tag == epoch_snap_q);
  assign rd_valid_o = valid_q;
  assign rd_hit_o   = hit;
  assign rd_data_o  = hit ? ram_rdata_i[DATA_W-1:0] : '0;
endmodule

// File: rtl/epoch_clear_table.sv
module epoch_clear_table #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned EW    = TAG_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic              clr_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              ram_we;
  logic [AW-1:0]     ram_addr;
  logic [EW-1:0]     ram_wdata, ram_rdata;
  logic [TAG_W-1:0]  epoch;
  logic              busy;

  etab_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .busy_o     (busy),
    .epoch_o    (epoch),
    .ram_we_o   (ram_we),
    .ram_addr_o (ram_addr),
    .ram_wdata_o(ram_wdata)
  );

  etab_ram #(.DEPTH(DEPTH), .WIDTH(EW)) i_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .waddr_i(ram_addr),
    .wdata_i(ram_wdata),
    .re_i   (rd_en_i),
    .raddr_i(rd_addr_i),
    .rdata_o(ram_rdata)
  );

  etab_rdstage #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .epoch_i    (epoch),
    .busy_i     (busy),
    .ram_rdata_i(ram_rdata),
    .rd_valid_o (rd_valid_o),
    .rd_hit_o   (rd_hit_o),
    .rd_data_o  (rd_data_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/etab_checker.sv
module etab_checker #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CW    = $clog2(DEPTH + 2) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              clr_i,
  input logic              busy_o,
  input logic              rd_valid_o,
  input logic              rd_hit_o,
  input logic [DATA_W-1:0] rd_data_o
);
  logic [CW-1:0] busy_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run_q <= '0;
    else         busy_run_q <= busy_o ? busy_run_q + CW'(1) : '0;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o); // R2
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_o |-> rd_valid_o); // R2
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_hit_o) |-> (rd_data_o == '0)); // R4
  AST_BUSY_READ_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_en_i) |=> !rd_hit_o); // R11
  AST_SCRUB_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_run_q == CW'(DEPTH))); // R8
  AST_SCRUB_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run_q <= CW'(DEPTH)); // R10
endmodule

bind epoch_clear_table etab_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_en_i   (rd_en_i),
  .clr_i     (clr_i),
  .busy_o    (busy_o),
  .rd_valid_o(rd_valid_o),
  .rd_hit_o  (rd_hit_o),
  .rd_data_o (rd_data_o)
);

// File: tb/test_epoch_clear_table.sv
`timescale 1ns/1ps
module test_epoch_clear_table;
  localparam int unsigned DEPTH  = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned TAG_W  = 2;
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned LAST   = (1 << TAG_W) - 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [AW-1:0]     wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              rd_en_i = 1'b0;
  logic [AW-1:0]     rd_addr_i = '0;
  logic              clr_i = 1'b0;
  logic              busy_o, rd_valid_o, rd_hit_o;
  logic [DATA_W-1:0] rd_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  epoch_clear_table #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_epoch_clear_table (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .clr_i(clr_i),
    .busy_o(busy_o), .rd_valid_o(rd_valid_o), .rd_hit_o(rd_hit_o), .rd_data_o(rd_data_o)
  );

  // reference model
  bit                m_vld [DEPTH];
  logic [DATA_W-1:0] m_dat [DEPTH];
  int unsigned       m_epoch = 0;
  int unsigned       m_busy  = 0;

  function automatic bit exp_hit(input logic [AW-1:0] a);
    return (m_busy == 0) && m_vld[a];
  endfunction

  function automatic logic [DATA_W-1:0] exp_data(input logic [AW-1:0] a);
    return exp_hit(a) ? m_dat[a] : '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [AW-1:0] wa, input logic [DATA_W-1:0] wd,
                      input bit re, input logic [AW-1:0] ra, input bit cl, input string tag);
    bit                eh;
    logic [DATA_W-1:0] ed;
    bit                wrap;
    chk(busy_o == (m_busy > 0), "R8 busy", busy_o, m_busy > 0);
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    rd_en_i = re; rd_addr_i = ra; clr_i = cl;
    eh = re && exp_hit(ra);
    ed = re ? exp_data(ra) : '0;
    wrap = 1'b0;
    if (m_busy > 0) begin
      m_busy--;
    end else begin
      if (cl) begin
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
        if (m_epoch == LAST) begin
          wrap = 1'b1; m_epoch = 0; m_busy = DEPTH;
        end else begin
          m_epoch++;
        end
      end
      if (we && !wrap) begin
        m_vld[wa] = 1'b1; m_dat[wa] = wd;
      end
    end
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0; clr_i = 1'b0;
    chk(rd_valid_o == re, "R2 valid", rd_valid_o, re);
    if (re) begin
      chk(rd_hit_o == eh, {tag, " hit"}, rd_hit_o, eh);
      chk(rd_data_o == ed, {tag, " data"}, rd_data_o, ed);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b1, AW'(i), 1'b0, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 1'b0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    m_busy = DEPTH;
    chk(busy_o == 1'b1, "R1 busy after reset", busy_o, 1);
    chk(rd_valid_o == 1'b0, "R1 valid after reset", rd_valid_o, 0);
    idle(DEPTH, "R11");               // reads during the reset scrub
    idle(DEPTH, "R1");                // every entry misses after it
    // R3 write then read
    step(1'b1, 3'd3, 8'hAA, 1'b0, 3'd0, 1'b0, "R3");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd3, 1'b0, "R3");
    // R7 read-first on same address
    step(1'b1, 3'd3, 8'hBB, 1'b1, 3'd3, 1'b0, "R7");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd3, 1'b0, "R7");
    // R5 clear, then read
    step(1'b1, 3'd4, 8'h44, 1'b0, 3'd0, 1'b0, "R5");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 1'b1, "R5");  // read-first sees old epoch
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 1'b0, "R5");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd3, 1'b0, "R5");
    // R6 write alongside a non-wrapping clear
    step(1'b1, 3'd5, 8'hCC, 1'b0, 3'd0, 1'b1, "R6");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 1'b0, "R6");
    // R8 wrapping clear drops the write and starts a scrub
    step(1'b1, 3'd6, 8'hDD, 1'b0, 3'd0, 1'b1, "R8");
    step(1'b1, 3'd1, 8'h11, 1'b1, 3'd5, 1'b0, "R9");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 1'b1, "R10");
    idle(DEPTH - 2, "R11");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 1'b0, "R9");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 1'b0, "R8");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 1'b0, "R8");
    step(1'b1, 3'd2, 8'h22, 1'b0, 3'd0, 1'b0, "R3");
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 1'b0, "R3");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      step(($urandom_range(3) != 0), AW'($urandom_range(DEPTH - 1)), DATA_W'($urandom),
           ($urandom_range(3) != 0), AW'($urandom_range(DEPTH - 1)),
           ($urandom_range(19) == 0), "R3 R4 random");
    end
    done = 1'b1;
    finish_run();
  end
endmodule